// File: doc/BRIEF.md
# Two-Card Striped Sector Mapper

This block sits between a host-facing sector interface and a pair of storage cards that together hold one encrypted volume. It takes one logical sector number per request. It returns three things: the card that holds that sector, the sector number on that card, and the 16-byte tweak nonce that the cipher stage will use for that sector. Logical sectors alternate between the two cards, so even numbers go to card A and odd numbers go to card B. Physical sector 0 on each card holds key material, so data is placed from physical sector 1 upward.

The nonce for a sector is built from the card that is not being accessed. Its first twelve bytes are the leading twelve bytes of that other card's stored nonce, and its last four bytes are the logical sector number. The block also reports the usable logical capacity, which it derives from the smaller card. Any request at or beyond that capacity comes back flagged as an error, with no card address.

Requests and responses each use a valid/ready handshake. The response is registered and appears one cycle after the request is accepted.

Top module: `sm_stripe_mapper`

## Requirements
- R1: For an in-range request, `rsp_card_o` equals bit 0 of the logical sector number, where 0 selects card A and 1 selects card B.
- R2: For an in-range request, `rsp_pba_o` equals the logical sector number divided by two (rounded down) plus one, so it is never 0.
- R3: `capacity_o` is combinational from the two sector counts and equals 2*(min(A,B)-1). It is 0 when either count is 0.
- R4: Nonce bits 127:32 (bytes 0 to 11, where byte 0 is bits 127:120) equal the stored leading-twelve-byte value of the opposite card. An access to card A uses B's value, and an access to card B uses A's value.
- R5: Nonce bits 31:0 (bytes 12 to 15) hold the logical sector number, zero-extended and big-endian, so its most significant byte is in byte 12.
- R6: A request whose sector number is greater than or equal to `capacity_o` completes with `rsp_err_o`=1, and with card, physical sector and nonce all 0. In-range requests have `rsp_err_o`=0.
- R7: `req_ready_o` is high exactly when no response is held or the held response is being taken. An accepted request yields `rsp_valid_o` on the following cycle.
- R8: While `rsp_valid_o` is high and `rsp_ready_i` is low, all response fields hold steady and `req_ready_o` is low.
- R9: After reset, `rsp_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_lba_i | input | CNT_W+1 | Logical sector number |
| sectors_a_i | input | CNT_W | Sector count of card A |
| sectors_b_i | input | CNT_W | Sector count of card B |
| seed_a_i | input | 8*KEEP_BYTES | Leading bytes of card A's stored nonce |
| seed_b_i | input | 8*KEEP_BYTES | Leading bytes of card B's stored nonce |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken |
| rsp_card_o | output | 1 | Card select (0 = A, 1 = B) |
| rsp_pba_o | output | CNT_W | Physical sector on the chosen card |
| rsp_nonce_o | output | 8*(KEEP_BYTES+TAIL_BYTES) | Tweak nonce |
| rsp_err_o | output | 1 | Request was out of range |
| capacity_o | output | CNT_W+1 | Usable logical sector count |

## Verification
The bench builds the block with CNT_W=7, so logical numbers are 8 bits wide and card counts go up to 127. With that width, every logical number from 0 to 255 can be swept in one run. That sweep reaches the exact capacity edge, the largest possible capacity (252), and the addresses beyond it. Card counts of 0 and 1 are also reachable, which drives the zero-capacity case where every request is an error. Random back-pressure on `rsp_ready_i` exercises the hold behaviour across the whole sweep.

// File: rtl/sm_pkg.sv
package sm_pkg;
  // Card select encoding: the stripe bit picks the card directly.
  typedef enum logic {
    CARD_A = 1'b0,
    CARD_B = 1'b1
  } card_e;

  // Nonce layout in bytes.
  localparam int unsigned DEF_KEEP_BYTES = 12;
  localparam int unsigned DEF_TAIL_BYTES = 4;
endpackage

// File: rtl/sm_capacity.sv
module sm_capacity #(
  parameter int unsigned CNT_W = 31
) (
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  output logic [CNT_W:0]   cap_o,
  output logic             cap_zero_o
);
  function automatic logic [CNT_W-1:0] smaller(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Each card loses its key sector; both cards contribute one stripe each.
  function automatic logic [CNT_W:0] usable(input logic [CNT_W-1:0] m);
    logic [CNT_W-1:0] data_secs;
    if (m == '0) return '0;
    data_secs = m - 1'b1;
    return {data_secs, 1'b0};
  endfunction

  logic [CNT_W-1:0] min_w;
  assign min_w      = smaller(cnt_a_i, cnt_b_i);
  assign cap_o      = usable(min_w);
  assign cap_zero_o = (cap_o == '0);
endmodule

// File: rtl/sm_locate.sv
module sm_locate #(
  parameter int unsigned CNT_W = 31,
  localparam int unsigned LBA_W = CNT_W + 1
) (
  input  logic [LBA_W-1:0] lba_i,
  input  logic [CNT_W:0]   cap_i,
  output sm_pkg::card_e    card_o,
  output logic [CNT_W-1:0] pba_o,
  output logic             in_range_o
);
  function automatic logic [CNT_W-1:0] to_physical(input logic [LBA_W-1:0] lba);
    logic [CNT_W-1:0] half;
    half = lba[LBA_W-1:1];
    return half + 1'b1;
  endfunction

  assign card_o     = sm_pkg::card_e'(lba_i[0]);
  assign pba_o      = to_physical(lba_i);
  assign in_range_o = (lba_i < cap_i);
endmodule

// File: rtl/sm_nonce.sv
module sm_nonce #(
  parameter int unsigned LBA_W      = 32,
  parameter int unsigned KEEP_BYTES = sm_pkg::DEF_KEEP_BYTES,
  parameter int unsigned TAIL_BYTES = sm_pkg::DEF_TAIL_BYTES,
  localparam int unsigned KEEP_W    = 8 * KEEP_BYTES,
  localparam int unsigned TAIL_W    = 8 * TAIL_BYTES,
  localparam int unsigned NONCE_W   = KEEP_W + TAIL_W
) (
  input  sm_pkg::card_e     card_i,
  input  logic [KEEP_W-1:0] seed_a_i,
  input  logic [KEEP_W-1:0] seed_b_i,
  input  logic [LBA_W-1:0]  lba_i,
  output logic [NONCE_W-1:0] nonce_o
);
  logic [KEEP_W-1:0] other_w;
  logic [TAIL_W-1:0] tail_w;

  // The nonce always comes from the card that is not touched.
  assign other_w = (card_i == sm_pkg::CARD_A) ? seed_b_i : seed_a_i;

  generate
    if (LBA_W == TAIL_W) begin : g_tail_exact
      assign tail_w = lba_i;
    end else if (LBA_W < TAIL_W) begin : g_tail_pad
      assign tail_w = {{(TAIL_W - LBA_W){1'b0}}, lba_i};
    end else begin : g_tail_bad
      initial $error("sm_nonce: logical number wider than nonce tail");
      assign tail_w = lba_i[TAIL_W-1:0];
    end
  endgenerate

  // Big-endian: the most significant byte of each field sits at the lower byte index.
  assign nonce_o = {other_w, tail_w};
endmodule

// File: rtl/sm_stripe_mapper.sv
module sm_stripe_mapper #(
  parameter int unsigned CNT_W      = 31,
  parameter int unsigned KEEP_BYTES = sm_pkg::DEF_KEEP_BYTES,
  parameter int unsigned TAIL_BYTES = sm_pkg::DEF_TAIL_BYTES,
  localparam int unsigned LBA_W     = CNT_W + 1,
  localparam int unsigned KEEP_W    = 8 * KEEP_BYTES,
  localparam int unsigned NONCE_W   = 8 * (KEEP_BYTES + TAIL_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LBA_W-1:0]   req_lba_i,
  input  logic [CNT_W-1:0]   sectors_a_i,
  input  logic [CNT_W-1:0]   sectors_b_i,
  input  logic [KEEP_W-1:0]  seed_a_i,
  input  logic [KEEP_W-1:0]  seed_b_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic               rsp_card_o,
  output logic [CNT_W-1:0]   rsp_pba_o,
  output logic [NONCE_W-1:0] rsp_nonce_o,
  output logic               rsp_err_o,
  output logic [CNT_W:0]     capacity_o
);
  // Named internal events.
  logic accept_w, stall_w, in_range_w, cap_zero_w;
  sm_pkg::card_e     card_w;
  logic [CNT_W-1:0]   pba_w;
  logic [NONCE_W-1:0] nonce_w;

  sm_capacity #(.CNT_W(CNT_W)) u_cap (
    .cnt_a_i   (sectors_a_i),
    .cnt_b_i   (sectors_b_i),
    .cap_o     (capacity_o),
    .cap_zero_o(cap_zero_w)
  );

  sm_locate #(.CNT_W(CNT_W)) u_loc (
    .lba_i     (req_lba_i),
    .cap_i     (capacity_o),
    .card_o    (card_w),
    .pba_o     (pba_w),
    .in_range_o(in_range_w)
  );

  sm_nonce #(
    .LBA_W     (LBA_W),
    .KEEP_BYTES(KEEP_BYTES),
    .TAIL_BYTES(TAIL_BYTES)
  ) u_non (
    .card_i  (card_w),
    .seed_a_i(seed_a_i),
    .seed_b_i(seed_b_i),
    .lba_i   (req_lba_i),
    .nonce_o (nonce_w)
  );

  assign stall_w     = rsp_valid_o && !rsp_ready_i;
  assign req_ready_o = !stall_w;
  assign accept_w    = req_valid_i && req_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_card_o  <= 1'b0;
      rsp_pba_o   <= '0;
      rsp_nonce_o <= '0;
      rsp_err_o   <= 1'b0;
    end else if (accept_w) begin
      rsp_valid_o <= 1'b1;
      rsp_err_o   <= !in_range_w;
      rsp_card_o  <= in_range_w ? logic'(card_w) : 1'b0;
      rsp_pba_o   <= in_range_w ? pba_w : '0;
      rsp_nonce_o <= in_range_w ? nonce_w : '0;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> rsp_valid_o);

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> rsp_valid_o && $stable(rsp_pba_o) && $stable(rsp_nonce_o)
                && $stable(rsp_err_o) && $stable(rsp_card_o));

  // R2
  key_sector_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_err_o |-> rsp_pba_o != '0);

  // R6
  error_no_address_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_err_o |-> rsp_pba_o == '0 && rsp_nonce_o == '0);

  // R1
  card_matches_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_err_o |-> rsp_card_o == rsp_nonce_o[0]);

  // R3
  capacity_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capacity_o <= {sectors_a_i, 1'b0} && capacity_o <= {sectors_b_i, 1'b0});

  // R6
  zero_capacity_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && cap_zero_w |=> rsp_err_o);
endmodule

// File: tb/sm_stripe_mapper_tb.sv
module sm_stripe_mapper_tb_top;
  localparam int CNT_W   = 7;
  localparam int LBA_W   = CNT_W + 1;
  localparam int KEEP_W  = 96;
  localparam int NONCE_W = 128;
  localparam int EXP_W   = 2 + CNT_W + NONCE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [LBA_W-1:0]   req_lba = '0;
  logic [CNT_W-1:0]   sec_a = '0, sec_b = '0;
  logic [KEEP_W-1:0]  seed_a = '0, seed_b = '0;
  logic               rsp_valid, rsp_card, rsp_err;
  logic               rsp_ready = 1'b1;
  logic [CNT_W-1:0]   rsp_pba;
  logic [NONCE_W-1:0] rsp_nonce;
  logic [CNT_W:0]     capacity;

  sm_stripe_mapper #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_lba_i(req_lba),
    .sectors_a_i(sec_a), .sectors_b_i(sec_b),
    .seed_a_i(seed_a), .seed_b_i(seed_b),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_card_o(rsp_card), .rsp_pba_o(rsp_pba), .rsp_nonce_o(rsp_nonce),
    .rsp_err_o(rsp_err), .capacity_o(capacity)
  );

  int checks = 0;
  int fails  = 0;
  logic [EXP_W-1:0] exp_q[$];
  bit bp_on = 1'b0;
  logic [7:0] lf = 8'hA5;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model written from the requirements.
  function automatic int model_cap(input int a, input int b);
    int m;
    m = (a < b) ? a : b;
    return (m == 0) ? 0 : 2 * (m - 1);
  endfunction

  function automatic logic [EXP_W-1:0] model(input int lba);
    int cap;
    logic [NONCE_W-1:0] n;
    cap = model_cap(int'(sec_a), int'(sec_b));
    if (lba >= cap) return {1'b1, 1'b0, {CNT_W{1'b0}}, {NONCE_W{1'b0}}};
    n = (NONCE_W'((lba % 2 == 0) ? seed_b : seed_a) << 32) + NONCE_W'(lba);
    return {1'b0, 1'(lba % 2), CNT_W'(lba / 2 + 1), n};
  endfunction

  // Back-pressure source.
  always @(posedge clk) begin
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    rsp_ready = bp_on ? lf[0] : 1'b1;
  end

  // Monitor: compare responses, check hold while stalled.
  bit prev_stall = 1'b0;
  logic [EXP_W-1:0] prev_rsp;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(rsp_valid && {rsp_err, rsp_card, rsp_pba, rsp_nonce} == prev_rsp,
              "R8 hold", 128'({rsp_card, rsp_pba}), 128'(prev_rsp[NONCE_W +: CNT_W+1]));
      end
      if (rsp_valid && !rsp_ready)
        check(!req_ready, "R8 ready low", 128'(req_ready), 128'(0));
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected response", 128'(1), 128'(0));
        end else begin
          logic [EXP_W-1:0] e;
          e = exp_q.pop_front();
          check(rsp_err == e[EXP_W-1], "R6 err", 128'(rsp_err), 128'(e[EXP_W-1]));
          check(rsp_card == e[EXP_W-2], "R1 card", 128'(rsp_card), 128'(e[EXP_W-2]));
          check(rsp_pba == e[NONCE_W +: CNT_W], "R2/R6 pba",
                128'(rsp_pba), 128'(e[NONCE_W +: CNT_W]));
          check(rsp_nonce[127:32] == e[127:32], "R4 nonce head",
                128'(rsp_nonce[127:32]), 128'(e[127:32]));
          check(rsp_nonce[31:0] == e[31:0], "R5 nonce tail",
                128'(rsp_nonce[31:0]), 128'(e[31:0]));
        end
      end
      prev_stall = rsp_valid && !rsp_ready;
      prev_rsp   = {rsp_err, rsp_card, rsp_pba, rsp_nonce};
    end
  end

  // Driver: one request, scoreboard push on acceptance, latency check.
  task automatic send(input int lba);
    bit acc;
    req_valid = 1'b1;
    req_lba   = LBA_W'(lba);
    do begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk);
      if (acc) exp_q.push_back(model(lba));
      #1;
    end while (!acc);
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid, "R7 latency", 128'(rsp_valid), 128'(1));
    @(posedge clk);
    #1;
  endtask

  task automatic set_cards(input int a, input int b);
    sec_a = CNT_W'(a);
    sec_b = CNT_W'(b);
    @(negedge clk);
    check(capacity == (CNT_W+1)'(model_cap(a, b)), "R3 capacity",
          128'(capacity), 128'(model_cap(a, b)));
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    bp_on = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R7 drained", 128'(exp_q.size()), 128'(0));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    join_none
    seed_a = 96'h0123_4567_89AB_CDEF_1122_3344;
    seed_b = 96'hFEDC_BA98_7654_3210_5566_7788;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(!rsp_valid, "R9 valid", 128'(rsp_valid), 128'(0));
    check(req_ready, "R9 ready", 128'(req_ready), 128'(1));
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    set_cards(0, 5);
    set_cards(100, 60);
    set_cards(2, 3);
    set_cards(1, 50);
    for (int i = 0; i < 4; i++) send(i);   // zero capacity: all errors (R6)
    drain();

    set_cards(20, 13);                      // capacity 24
    for (int i = 0; i < 31; i++) send(i);   // crosses the edge (R6)
    drain();

    set_cards(127, 127);                    // capacity 252
    seed_a = 96'hA5A5_0000_FFFF_1234_5678_9ABC;
    bp_on = 1'b1;
    for (int i = 0; i < 256; i++) send(i);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule